// File: doc/BRIEF.md
# Key-Protected Fault Status Register

This block holds a six-bit sticky fault status word: summary flags for critical, non-critical and stay-in-reset faults, plus flags for a self-test watchdog timeout, an engine execution error and a bad test-list pointer. Hardware raises any flag with a one-cycle pulse on its set input. Software reads the word over a small register bus. It may change the word only after it writes an unlock key to a companion key register.

Two 32-bit key constants exist. One arms a clear mode and the other arms a set mode. The key written last decides the mode. An armed key allows exactly one write to the status word. The key lapses if that write does not arrive within a fixed number of cycles. Any access the block does not accept gets a transfer error and discards the armed key. The bus response, read data and transfer error, is registered and appears in the cycle after the access.

Top module: `fsr_errreg_top`

## Requirements
- R1: After reset all six flags read 0, the key register reads 0 (no mode) and bus_err is 0.
- R2: A pulse on hw_set[i] makes flag i read 1 from then on. The bit order is: 0 critical, 1 non-critical, 2 stay-in-reset, 3 watchdog timeout, 4 engine error, 5 bad pointer. A read of the status register (offset 0x0) returns the flags in bits 5:0 and zeros above, in the cycle after the read.
- R3: Writing 0x5AF00FA5 to the key register (offset 0x4) arms clear mode, and writing 0xA50FF05A arms set mode. A read of the key register returns 0 for none, 1 for clear and 2 for set. When two keys are written in a row, the second one decides the mode.
- R4: In clear mode, a status write clears every flag whose data bit is 1 and leaves the other flags unchanged. Data bits 31:6 have no effect.
- R5: In set mode, a status write sets every flag whose data bit is 1 and leaves the other flags unchanged.
- R6: An armed key is used up by one accepted status write. The key register then reads 0, and a second status write is rejected.
- R7: A status write with no armed key raises bus_err in the next cycle and leaves the flags unchanged.
- R8: Writing any value other than the two keys to the key register raises bus_err and discards any armed key.
- R9: An access that asserts read and write together, or that targets an offset other than 0x0 or 0x4, raises bus_err and discards any armed key.
- R10: A status write accepted by the key must arrive no more than TIMEOUT cycles after the key write cycle. If no status write arrives in that window, the key lapses, and a status write TIMEOUT+1 cycles after the key write is rejected with bus_err.
- R11: When hw_set[i] arrives in the same cycle as a software clear of flag i, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_set | input | 6 | Per-flag set pulses from the fault sources |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Transfer error, the cycle after a rejected access |

## Verification
The bench sweeps every pair of set and clear patterns on the six flags. A design that inverted the mask, or that let data bits above the flag field leak through, produces wrong bits. The bench probes the key window at exactly TIMEOUT cycles and at TIMEOUT+1 cycles. An off-by-one counter either rejects the last legal write or accepts a late one. The bench also checks that a key is used up, that the last key wins, and that bad keys, unmapped offsets and combined read-write strobes discard the key. A design that kept the key alive would accept a later write without bus_err. A pulse on a hardware set input that collides with a software clear shows whether the hardware set has priority.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_CLR  = 2'd1,
        MODE_SET  = 2'd2
    } fsr_mode_e;

    typedef enum logic [2:0] {
        ACC_IDLE   = 3'd0,
        ACC_RD_ERR = 3'd1,
        ACC_RD_KEY = 3'd2,
        ACC_WR_ERR = 3'd3,
        ACC_WR_KEY = 3'd4,
        ACC_BAD    = 3'd5
    } fsr_acc_e;

endpackage

// File: rtl/fsr_bus_decode.sv
module fsr_bus_decode
    import fsr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int ERR_OFS = 0,
    parameter int KEY_OFS = 4
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output fsr_acc_e          acc
);
    localparam logic [ADDR_W-1:0] ERR_A = ADDR_W'(ERR_OFS);
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFS);

    always_comb begin
        acc = ACC_IDLE;
        if (rd && wr) begin
            acc = ACC_BAD;
        end else if (rd) begin
            if (addr == ERR_A)      acc = ACC_RD_ERR;
            else if (addr == KEY_A) acc = ACC_RD_KEY;
            else                    acc = ACC_BAD;
        end else if (wr) begin
            if (addr == ERR_A)      acc = ACC_WR_ERR;
            else if (addr == KEY_A) acc = ACC_WR_KEY;
            else                    acc = ACC_BAD;
        end
    end
endmodule

// File: rtl/fsr_key_guard.sv
module fsr_key_guard
    import fsr_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          TIMEOUT = 8,
    parameter logic [31:0] KEY_CLR = 32'h5AF0_0FA5,
    parameter logic [31:0] KEY_SET = 32'hA50F_F05A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fsr_acc_e          acc,
    input  logic [DATA_W-1:0] wdata,
    output fsr_mode_e         mode,
    output logic              wr_ok,
    output logic              key_bad
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        fsr_mode_e        mode;
        logic [CNT_W-1:0] cnt;
    } guard_t;

    guard_t st_d, st_q;
    logic   is_clr_key, is_set_key;

    always_comb begin
        st_d       = st_q;
        is_clr_key = (wdata[31:0] == KEY_CLR);
        is_set_key = (wdata[31:0] == KEY_SET);
        key_bad    = (acc == ACC_WR_KEY) && !is_clr_key && !is_set_key;
        wr_ok      = (acc == ACC_WR_ERR) && (st_q.mode != MODE_NONE);

        if (acc == ACC_BAD || key_bad) begin
            st_d.mode = MODE_NONE;
            st_d.cnt  = '0;
        end else if (acc == ACC_WR_KEY) begin
            st_d.mode = is_clr_key ? MODE_CLR : MODE_SET;
            st_d.cnt  = CNT_LOAD;
        end else if (acc == ACC_WR_ERR) begin
            st_d.mode = MODE_NONE;
            st_d.cnt  = '0;
        end else if (st_q.mode != MODE_NONE) begin
            if (st_q.cnt == '0) st_d.mode = MODE_NONE;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_NONE;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    // R8
    bad_key_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> (mode == MODE_NONE));

    // R6
    key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (mode == MODE_NONE));

    // R10
    key_lapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_NONE && st_q.cnt == '0 && acc == ACC_IDLE) |=> (mode == MODE_NONE));

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NONE || mode == MODE_CLR || mode == MODE_SET));
endmodule

// File: rtl/fsr_flag_bank.sv
module fsr_flag_bank #(
    parameter int FLAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] hw_set,
    input  logic [FLAG_W-1:0] clr_mask,
    input  logic [FLAG_W-1:0] set_mask,
    output logic [FLAG_W-1:0] flags
);
    typedef struct packed {
        logic [FLAG_W-1:0] bits;
    } bank_t;

    bank_t             bank_d, bank_q;
    logic [FLAG_W-1:0] nxt;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        always_comb begin
            nxt[i] = bank_q.bits[i];
            if (clr_mask[i])                nxt[i] = 1'b0;
            if (set_mask[i] || hw_set[i])   nxt[i] = 1'b1;
        end

        // R4
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_q.bits[i] && !clr_mask[i]) |=> bank_q.bits[i]);

        // R2
        hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> bank_q.bits[i]);
    end

    always_comb begin
        bank_d.bits = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q.bits <= '0;
        else        bank_q      <= bank_d;
    end

    assign flags = bank_q.bits;
endmodule

// File: rtl/fsr_errreg_top.sv
module fsr_errreg_top
    import fsr_pkg::*;
#(
    parameter int          FLAG_W  = 6,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 4,
    parameter int          ERR_OFS = 0,
    parameter int          KEY_OFS = 4,
    parameter int          TIMEOUT = 8,
    parameter logic [31:0] KEY_CLR = 32'h5AF0_0FA5,
    parameter logic [31:0] KEY_SET = 32'hA50F_F05A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] hw_set,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_t;

    fsr_acc_e          acc;
    fsr_mode_e         mode;
    logic              wr_ok, key_bad;
    logic [FLAG_W-1:0] flags, clr_mask, set_mask;
    rsp_t              rsp_d, rsp_q;

    fsr_bus_decode #(
        .ADDR_W (ADDR_W),
        .ERR_OFS(ERR_OFS),
        .KEY_OFS(KEY_OFS)
    ) u_dec (
        .rd  (bus_rd),
        .wr  (bus_wr),
        .addr(bus_addr),
        .acc (acc)
    );

    fsr_key_guard #(
        .DATA_W (DATA_W),
        .TIMEOUT(TIMEOUT),
        .KEY_CLR(KEY_CLR),
        .KEY_SET(KEY_SET)
    ) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .wdata  (bus_wdata),
        .mode   (mode),
        .wr_ok  (wr_ok),
        .key_bad(key_bad)
    );

    always_comb begin
        clr_mask = '0;
        set_mask = '0;
        if (wr_ok && mode == MODE_CLR) clr_mask = bus_wdata[FLAG_W-1:0];
        if (wr_ok && mode == MODE_SET) set_mask = bus_wdata[FLAG_W-1:0];
    end

    fsr_flag_bank #(
        .FLAG_W(FLAG_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (hw_set),
        .clr_mask(clr_mask),
        .set_mask(set_mask),
        .flags   (flags)
    );

    always_comb begin
        rsp_d.rdata = '0;
        rsp_d.err   = (acc == ACC_BAD) || key_bad ||
                      (acc == ACC_WR_ERR && !wr_ok);
        if (acc == ACC_RD_ERR) rsp_d.rdata = {{(DATA_W-FLAG_W){1'b0}}, flags};
        if (acc == ACC_RD_KEY) rsp_d.rdata = {{(DATA_W-2){1'b0}}, mode};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q.rdata <= '0;
            rsp_q.err   <= 1'b0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rdata = rsp_q.rdata;
    assign bus_err   = rsp_q.err;

    // R7
    unkeyed_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == ADDR_W'(ERR_OFS) && mode == MODE_NONE)
        |=> bus_err);

    // R7
    unkeyed_flags_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NONE && hw_set == '0) |=> $stable(flags));

    // R9
    bad_access_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> (bus_err && mode == MODE_NONE));
endmodule

// File: tb/fsr_errreg_top_tb_top.sv
module fsr_errreg_top_tb_top;
    localparam int          TMO  = 8;
    localparam logic [3:0]  A_ERR = 4'h0;
    localparam logic [3:0]  A_KEY = 4'h4;
    localparam logic [31:0] K_CLR = 32'h5AF0_0FA5;
    localparam logic [31:0] K_SET = 32'hA50F_F05A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  hw_set = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic        e;
    logic [31:0] r;

    always #2 clk = ~clk;

    fsr_errreg_top dut_i (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with the response
    task automatic op(input logic rd, input logic wr, input logic [3:0] a,
                      input logic [31:0] d, input logic [5:0] hw,
                      output logic err, output logic [31:0] rdv);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; hw_set = hw;
        @(negedge clk);
        err = bus_err; rdv = bus_rdata;
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; hw_set = '0;
    endtask

    task automatic rd_flags(input string req, input logic [5:0] exp);
        op(1'b1, 1'b0, A_ERR, '0, '0, e, r);
        check(req, r, {26'd0, exp});
    endtask

    task automatic rd_mode(input string req, input logic [1:0] exp);
        op(1'b1, 1'b0, A_KEY, '0, '0, e, r);
        check(req, r, {30'd0, exp});
    endtask

    task automatic keyed_write(input logic [31:0] key, input logic [31:0] d, input string req);
        op(1'b0, 1'b1, A_KEY, key, '0, e, r);
        check({req, " key err"}, {31'd0, e}, 32'd0);
        op(1'b0, 1'b1, A_ERR, d, '0, e, r);
        check({req, " write err"}, {31'd0, e}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 err idle", {31'd0, bus_err}, 32'd0);
        rd_flags("R1 flags", 6'h00);
        rd_mode("R1 mode", 2'd0);

        // R2 each hardware source, accumulating
        for (int i = 0; i < 6; i++) begin
            op(1'b0, 1'b0, A_ERR, '0, 6'(1 << i), e, r);
            rd_flags("R2 hw set", 6'((1 << (i + 1)) - 1));
        end
        keyed_write(K_CLR, 32'h3F, "R4 clear all");
        rd_flags("R4 clear all", 6'h00);
        rd_mode("R6 consumed", 2'd0);

        // R4 R5 exhaustive set / clear sweep, junk in upper data bits
        for (int p = 0; p < 64; p++) begin
            for (int q = 0; q < 64; q++) begin
                keyed_write(K_SET, {26'h2AAAAAA, 6'(p)}, "R5 set");
                rd_flags("R5 set", 6'(p));
                keyed_write(K_CLR, {26'h3FFFFFF ^ 26'(q), 6'(q)}, "R4 clear");
                rd_flags("R4 clear", 6'(p) & ~6'(q));
                keyed_write(K_SET, {26'h1555555, 6'(q)}, "R5 set merge");
                rd_flags("R5 set merge", (6'(p) & ~6'(q)) | 6'(q));
                keyed_write(K_CLR, 32'h3F, "R4 reset flags");
            end
        end

        // R3 mode readback and last key wins
        op(1'b0, 1'b1, A_KEY, K_CLR, '0, e, r);
        rd_mode("R3 clear mode", 2'd1);
        op(1'b0, 1'b1, A_KEY, K_SET, '0, e, r);
        rd_mode("R3 set mode", 2'd2);
        op(1'b0, 1'b1, A_ERR, 32'h05, '0, e, r);
        check("R3 last key write err", {31'd0, e}, 32'd0);
        rd_flags("R3 last key sets", 6'h05);

        // R6 second write without new key
        op(1'b0, 1'b1, A_ERR, 32'h3F, '0, e, r);
        check("R6 reuse err", {31'd0, e}, 32'd1);
        rd_flags("R6 reuse flags", 6'h05);

        // R7 no key
        op(1'b0, 1'b1, A_ERR, 32'h00, '0, e, r);
        check("R7 unkeyed err", {31'd0, e}, 32'd1);
        rd_flags("R7 unchanged", 6'h05);

        // R8 bad key discards armed key
        op(1'b0, 1'b1, A_KEY, K_CLR, '0, e, r);
        op(1'b0, 1'b1, A_KEY, K_CLR ^ 32'h1, '0, e, r);
        check("R8 bad key err", {31'd0, e}, 32'd1);
        rd_mode("R8 key dropped", 2'd0);
        op(1'b0, 1'b1, A_ERR, 32'h3F, '0, e, r);
        check("R8 write after bad key", {31'd0, e}, 32'd1);
        rd_flags("R8 flags kept", 6'h05);

        // R9 read+write together
        op(1'b0, 1'b1, A_KEY, K_CLR, '0, e, r);
        op(1'b1, 1'b1, A_ERR, 32'h3F, '0, e, r);
        check("R9 rd+wr err", {31'd0, e}, 32'd1);
        rd_mode("R9 rd+wr drop", 2'd0);
        rd_flags("R9 rd+wr flags", 6'h05);

        // R9 unmapped offset
        op(1'b0, 1'b1, A_KEY, K_SET, '0, e, r);
        op(1'b1, 1'b0, 4'h8, '0, '0, e, r);
        check("R9 unmapped err", {31'd0, e}, 32'd1);
        check("R9 unmapped data", r, 32'd0);
        rd_mode("R9 unmapped drop", 2'd0);

        // R10 last legal cycle
        op(1'b0, 1'b1, A_KEY, K_CLR, '0, e, r);
        repeat (TMO - 1) @(negedge clk);
        op(1'b0, 1'b1, A_ERR, 32'h01, '0, e, r);
        check("R10 in window", {31'd0, e}, 32'd0);
        rd_flags("R10 in window", 6'h04);

        // R10 one cycle late
        op(1'b0, 1'b1, A_KEY, K_CLR, '0, e, r);
        repeat (TMO) @(negedge clk);
        op(1'b0, 1'b1, A_ERR, 32'h3F, '0, e, r);
        check("R10 late err", {31'd0, e}, 32'd1);
        rd_flags("R10 late flags", 6'h04);

        // R11 hardware set beats software clear
        keyed_write(K_SET, 32'h3F, "R11 prep");
        op(1'b0, 1'b1, A_KEY, K_CLR, '0, e, r);
        op(1'b0, 1'b1, A_ERR, 32'h3F, 6'h04, e, r);
        check("R11 write err", {31'd0, e}, 32'd0);
        rd_flags("R11 hw wins", 6'h04);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule